// File: doc/BRIEF.md
# PPM Trim Prescaler

This block turns a free-running 32768 Hz oscillator clock into a one-cycle tick once per second for a real-time clock. It also applies a small signed frequency correction of up to ±30 ppm, set by a 3-bit trim code. The correction is never spread inside one second. Instead, a fractional accumulator collects the requested error each second. When a whole oscillator cycle has built up, the following second is shortened or lengthened by exactly one cycle. The average rate over many seconds therefore matches the requested trim.

A second output flag rises together with the tick when the second that just ended was a corrected one. Downstream timekeeping logic counts the tick. A calibration monitor can watch the flag.

The oscillator count per second, the accumulator modulus and the ppm weight of one trim step are parameters. Their defaults are 32768 cycles, 1,000,000 and 10 ppm.

Top module: `ppm_trim_prescaler`

## Requirements
- R1: While `rst` is high, `tick_o` and `corr_o` are low. After `rst` is released, the first second lasts exactly CPS cycles and is not corrected. A reset at any time also clears the accumulator.
- R2: The trim code is decoded as follows. Bit 2 is the sign: 0 means positive compensation and 1 means negative. Bit 1 is worth 10 ppm and bit 0 is worth 20 ppm, so the magnitude is 0, 10, 20 or 30 ppm.
- R3: An uncorrected second lasts CPS clock cycles. `tick_o` is high for exactly one cycle, which is the last cycle of each second.
- R4: At every second boundary the accumulator adds |ppm| × CPS. If the sum reaches DEN, DEN is subtracted and the next second is corrected. Over the first ten seconds after reset, this gives 0, 2, 5 and 8 corrected seconds for 0, 10, 20 and 30 ppm, with CPS=32 and DEN=1000.
- R5: A corrected second lasts CPS−1 cycles when the sign is 0 and CPS+1 cycles when the sign is 1.
- R6: Codes 000 and 100 never produce a corrected second, and every second lasts CPS cycles.
- R7: `corr_o` is high in the cycle where `tick_o` is high if and only if the second ending there was corrected.
- R8: The trim code is sampled only at a second boundary, so a change in mid-second affects only later boundaries. The accumulator keeps its value across code changes, including a change of sign.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Oscillator clock |
| rst | input | 1 | Synchronous active-high reset |
| trim_i | input | 3 | Trim code: sign in bit 2, 10 ppm in bit 1, 20 ppm in bit 0 |
| tick_o | output | 1 | One-cycle pulse on the last cycle of each second |
| corr_o | output | 1 | High with `tick_o` when the ending second was corrected |

## Verification
Some properties are checked on every cycle:
- the accumulator stays below the modulus and holds its value between boundaries or when the magnitude is zero;
- the prescaler count wraps to zero and loads the next period only at a tick;
- every second's measured length matches its flag: CPS when unflagged, CPS±1 when flagged.

Other behaviour can only be shown by the bench's scenarios. These are the long-run number of corrected seconds for each code, the direction of the correction for each sign, the boundary-only sampling of a code changed mid-second, and the accumulator surviving a code change while being cleared by a reset.

// File: rtl/ppm_trim_pkg.sv
package ppm_trim_pkg;

    // Decoded trim: sign plus magnitude in units of one trim step
    typedef struct packed {
        logic       neg;
        logic [1:0] units;
    } trim_t;

    // Length class of one second
    typedef enum logic [1:0] {
        LEN_NOM   = 2'd0,
        LEN_SHORT = 2'd1,
        LEN_LONG  = 2'd2
    } len_sel_e;

    // Bit 1 weighs one step, bit 0 weighs two steps
    function automatic trim_t decode_trim(input logic [2:0] code);
        trim_t t;
        t.neg   = code[2];
        t.units = {code[0], code[1]};
        return t;
    endfunction

    // Choose the length of the coming second from the accumulator carry
    function automatic len_sel_e pick_len(input logic carry, input logic neg);
        if (!carry) begin
            return LEN_NOM;
        end
        return neg ? LEN_LONG : LEN_SHORT;
    endfunction

endpackage

// File: rtl/trim_decode.sv
module trim_decode
    import ppm_trim_pkg::*;
(
    input  logic [2:0] code_i,
    output trim_t      trim_o
);

    always_comb begin
        trim_o = decode_trim(code_i);
    end

endmodule

// File: rtl/frac_accum.sv
module frac_accum #(
    parameter int CPS      = 32768,
    parameter int DEN      = 1000000,
    parameter int UNIT_PPM = 10
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       boundary_i,
    input  logic [1:0] units_i,
    output logic       carry_o
);

    localparam int STEP_MAX = 3 * UNIT_PPM * CPS;
    localparam int ACC_W    = $clog2(DEN + STEP_MAX + 1);
    localparam logic [ACC_W-1:0] UNIT_STEP = ACC_W'(UNIT_PPM * CPS);
    localparam logic [ACC_W-1:0] DEN_V     = ACC_W'(DEN);

    logic [ACC_W-1:0] acc_q;
    logic [ACC_W-1:0] step;
    logic [ACC_W-1:0] sum;

    always_comb begin
        step    = ACC_W'(units_i) * UNIT_STEP;
        sum     = acc_q + step;
        carry_o = (sum >= DEN_V);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            acc_q <= '0;
        end else if (boundary_i) begin
            acc_q <= carry_o ? (sum - DEN_V) : sum;
        end
    end

    // R4
    acc_below_den_chk: assert property (@(posedge clk) disable iff (rst)
        acc_q < DEN_V);

    // R8
    acc_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !boundary_i |=> $stable(acc_q));

    // R6
    zero_trim_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (boundary_i && units_i == 2'd0) |=> $stable(acc_q));

endmodule

// File: rtl/sec_counter.sv
module sec_counter
    import ppm_trim_pkg::*;
#(
    parameter int CPS = 32768
) (
    input  logic     clk,
    input  logic     rst,
    input  len_sel_e next_sel_i,
    output logic     wrap_o,
    output logic     adjusted_o
);

    localparam int CNT_W = $clog2(CPS + 1);

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] last;
    len_sel_e         sel_q;

    always_comb begin
        case (sel_q)
            LEN_SHORT: last = CNT_W'(CPS - 2);
            LEN_LONG:  last = CNT_W'(CPS);
            default:   last = CNT_W'(CPS - 1);
        endcase
        wrap_o     = (cnt_q == last);
        adjusted_o = (sel_q != LEN_NOM);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
            sel_q <= LEN_NOM;
        end else if (wrap_o) begin
            cnt_q <= '0;
            sel_q <= next_sel_i;
        end else begin
            cnt_q <= cnt_q + CNT_W'(1);
        end
    end

    // R3
    cnt_range_chk: assert property (@(posedge clk) disable iff (rst)
        cnt_q <= CNT_W'(CPS));

    // R8
    wrap_load_chk: assert property (@(posedge clk) disable iff (rst)
        wrap_o |=> (cnt_q == '0) && (sel_q == $past(next_sel_i)));

    // R3
    count_step_chk: assert property (@(posedge clk) disable iff (rst)
        !wrap_o |=> (cnt_q == $past(cnt_q) + CNT_W'(1)) && $stable(sel_q));

endmodule

// File: rtl/ppm_trim_prescaler.sv
module ppm_trim_prescaler
    import ppm_trim_pkg::*;
#(
    parameter int CPS      = 32768,
    parameter int DEN      = 1000000,
    parameter int UNIT_PPM = 10
) (
    input  logic       clk,
    input  logic       rst,
    input  logic [2:0] trim_i,
    output logic       tick_o,
    output logic       corr_o
);

    localparam int RUN_W = $clog2(CPS + 2) + 1;

    trim_t    trim;
    logic     carry;
    logic     wrap;
    logic     adjusted;
    len_sel_e next_sel;

    trim_decode u_decode (
        .code_i (trim_i),
        .trim_o (trim)
    );

    frac_accum #(
        .CPS      (CPS),
        .DEN      (DEN),
        .UNIT_PPM (UNIT_PPM)
    ) u_accum (
        .clk        (clk),
        .rst        (rst),
        .boundary_i (wrap),
        .units_i    (trim.units),
        .carry_o    (carry)
    );

    always_comb begin
        next_sel = pick_len(carry, trim.neg);
    end

    sec_counter #(
        .CPS (CPS)
    ) u_count (
        .clk        (clk),
        .rst        (rst),
        .next_sel_i (next_sel),
        .wrap_o     (wrap),
        .adjusted_o (adjusted)
    );

    assign tick_o = wrap;
    assign corr_o = wrap & adjusted;

    // Length of the running second, kept only for the checks below
    logic [RUN_W-1:0] run_q;

    always_ff @(posedge clk) begin
        if (rst || tick_o) begin
            run_q <= RUN_W'(1);
        end else begin
            run_q <= run_q + RUN_W'(1);
        end
    end

    // R3
    plain_len_chk: assert property (@(posedge clk) disable iff (rst)
        (tick_o && !corr_o) |-> (run_q == RUN_W'(CPS)));

    // R5
    corr_len_chk: assert property (@(posedge clk) disable iff (rst)
        (tick_o && corr_o) |-> (run_q == RUN_W'(CPS - 1) || run_q == RUN_W'(CPS + 1)));

    // R1
    reset_quiet_chk: assert property (@(posedge clk)
        rst |=> !corr_o);

endmodule

// File: tb/ppm_trim_prescaler_tb.sv
module ppm_trim_prescaler_tb;

    localparam int CPS = 32;
    localparam int DEN = 1000;

    // Walked table: code, corrected seconds in ten, total cycles in ten
    localparam int CODES[8]     = '{0, 2, 1, 3, 4, 6, 5, 7};
    localparam int EXP_CORR[8]  = '{0, 2, 5, 8, 0, 2, 5, 8};
    localparam int EXP_TOTAL[8] = '{320, 318, 315, 312, 320, 322, 325, 328};

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [2:0] trim = 3'b000;
    logic       tick;
    logic       corr;

    int n_chk  = 0;
    int n_fail = 0;

    int len_log [16];
    bit corr_log[16];
    int n_sec = 0;
    int cyc   = 0;

    always #5 clk = ~clk;

    ppm_trim_prescaler #(
        .CPS (CPS),
        .DEN (DEN)
    ) u_dut (
        .clk    (clk),
        .rst    (rst),
        .trim_i (trim),
        .tick_o (tick),
        .corr_o (corr)
    );

    // Record length and flag of each second, sampled at the falling edge
    always @(negedge clk) begin
        if (rst) begin
            cyc   = 0;
            n_sec = 0;
        end else begin
            cyc = cyc + 1;
            if (tick) begin
                if (n_sec < 16) begin
                    len_log[n_sec]  = cyc;
                    corr_log[n_sec] = corr;
                end
                n_sec = n_sec + 1;
                cyc   = 0;
            end
        end
    end

    task automatic check(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic reset_dut(input logic [2:0] code);
        @(posedge clk);
        #1;
        rst  = 1'b1;
        trim = code;
        repeat (3) @(posedge clk);
        #1;
        check("R1 tick in reset", int'(tick), 0);
        check("R1 corr in reset", int'(corr), 0);
        @(posedge clk);
        #1;
        rst = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL R3 watchdog actual=timeout expected=completion");
        $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end

    initial begin
        // Table walk: R2 R4 R5 R6 R7 for every code
        for (int r = 0; r < 8; r++) begin
            int total;
            int ncorr;
            int bad;
            bit neg;
            reset_dut(3'(CODES[r]));
            wait (n_sec == 10);
            total = 0;
            ncorr = 0;
            bad   = 0;
            neg   = (CODES[r] & 4) != 0;
            for (int s = 0; s < 10; s++) begin
                int exp_len;
                total += len_log[s];
                if (corr_log[s]) ncorr++;
                exp_len = !corr_log[s] ? CPS : (neg ? CPS + 1 : CPS - 1);
                if (len_log[s] != exp_len) bad++;
            end
            check($sformatf("R4 R2 corrected count code=%0d", CODES[r]), ncorr, EXP_CORR[r]);
            check($sformatf("R4 total cycles code=%0d", CODES[r]), total, EXP_TOTAL[r]);
            check($sformatf("R5 R7 per-second mismatches code=%0d", CODES[r]), bad, 0);
            check($sformatf("R1 first second code=%0d", CODES[r]), len_log[0], CPS);
            if (EXP_CORR[r] == 0) begin
                check($sformatf("R6 no correction code=%0d", CODES[r]), ncorr, 0);
            end
        end

        // R8: mid-second changes; accumulator survives zero and sign change
        reset_dut(3'b010);
        wait (n_sec == 3);
        @(posedge clk);
        #1;
        trim = 3'b100;
        wait (n_sec == 4);
        @(posedge clk);
        #1;
        trim = 3'b110;
        wait (n_sec == 6);
        check("R8 s4 length", len_log[3], CPS);
        check("R8 s4 flag", int'(corr_log[3]), 0);
        check("R8 s5 length", len_log[4], CPS);
        check("R8 s6 length", len_log[5], CPS + 1);
        check("R8 s6 flag", int'(corr_log[5]), 1);

        // R1: reset mid-run clears the accumulator
        reset_dut(3'b011);
        wait (n_sec == 3);
        repeat (10) @(posedge clk);
        reset_dut(3'b011);
        wait (n_sec == 3);
        check("R1 after mid reset s1", len_log[0], CPS);
        check("R1 after mid reset s2", len_log[1], CPS);
        check("R1 after mid reset s2 flag", int'(corr_log[1]), 0);
        check("R5 after mid reset s3", len_log[2], CPS - 1);
        check("R7 after mid reset s3 flag", int'(corr_log[2]), 1);

        $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end

endmodule